// File: doc/BRIEF.md
# Fetch and Data Access Sequencer with Drain Control

This block is the control state machine of a small non-pipelined core that runs one instruction at a time. It issues instruction fetches on one request port and data accesses on a second, waits for each response, and steps the program counter. Decode, execution, address translation and the memories sit outside the block. A fetch attempt is exposed as a strobe with the current program counter, and a translation fault is returned in the same cycle. Data translation is a request and done/fault exchange.

Both request ports use a valid/accept handshake in the same cycle. A refused request is parked inside the block and sent again only when that port pulses its retry strobe. A response flagged as negatively acknowledged makes the block resend the same request at once. A drain request stops the core at the next instruction boundary. If nothing is in flight it completes in the same cycle. Otherwise it completes when the outstanding access returns. A free-running cycle counter measures the time spent active.

Top module: `fetch_mem_seq`

## Requirements
- R1: After reset the block is idle: no request valid, `drained` and `proto_err` low, `cycle_count` zero. An `activate` pulse in idle makes the block start a fetch on the following cycle with `fetch_pc` equal to RESET_PC.
- R2: While running and not drained, every cycle in which nothing is outstanding raises `fetch_start` with `fetch_pc` as the address, and `imem_valid` is raised with that address. A response whose bit IW-1 is 0 is a non-memory instruction: the PC advances by 4 and the next fetch starts on the next cycle.
- R3: A refused request raises no further `valid` on that port until its retry strobe. On the strobe the same address (and write flag) is presented again. Once accepted, the block waits for the response.
- R4: A retry strobe on a port whose request is not parked sets `proto_err`, and `proto_err` stays set until reset.
- R5: A response with its nack input high causes the same request to be presented again in that same cycle. If that resend is refused, the request is parked as in R3.
- R6: A response with bit IW-1 set is a memory instruction. Bit IW-2 is its write flag and bits AW-1:0 are its data address. In that cycle `dtb_req` rises with `dtb_vaddr` equal to that address. When `dtb_done` arrives without a fault, `dmem_valid` rises in that cycle with `dtb_paddr` and the write flag. The data response advances the PC by 4 and the next fetch follows.
- R7: A fetch translation fault (`ifetch_fault` during `fetch_start`) issues no instruction request. A data translation fault (`dtb_fault` with `dtb_done`) issues no data request. Either fault sets the PC to FAULT_VEC, and the next fetch starts there.
- R8: `drain_req` while idle, running or switched out raises `drained` in that same cycle, and no fetch starts until `activate`. `activate` clears the drained condition, and fetching resumes on the cycle after it.
- R9: `drain_req` while an access is in flight keeps `drained` low until the response arrives. `drained` then rises on the next cycle and no new fetch is started. An instruction response consumed this way leaves the PC unchanged. A data response advances it by 4.
- R10: `suspend` while running returns the block to idle with no fetch. `suspend` while idle has no effect. `switch_out` while running enters the switched-out state with no fetch, and `activate` leaves it.
- R11: `cycle_count` increments by one on every clock edge at which the block is neither idle nor switched out, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate | input | 1 | Start or resume the context |
| suspend | input | 1 | Suspend the context while running |
| switch_out | input | 1 | Hand the core off (switched-out state) |
| drain_req | input | 1 | Request a stop at the next instruction boundary |
| drained | output | 1 | Core is quiescent after a drain |
| proto_err | output | 1 | Sticky: retry strobe with nothing parked |
| cycle_count | output | CW | Active cycle counter |
| fetch_start | output | 1 | A fetch is attempted this cycle |
| fetch_pc | output | AW | Current program counter |
| ifetch_fault | input | 1 | Fetch translation fault, same cycle as fetch_start |
| imem_valid | output | 1 | Instruction request valid |
| imem_addr | output | AW | Instruction request address |
| imem_accept | input | 1 | Instruction port accepts this cycle |
| imem_retry | input | 1 | Instruction port retry strobe |
| imem_resp | input | 1 | Instruction response valid |
| imem_nack | input | 1 | Instruction response is a negative acknowledge |
| imem_rdata | input | IW | Instruction word |
| dtb_req | output | 1 | Data translation request |
| dtb_vaddr | output | AW | Data virtual address |
| dtb_done | input | 1 | Data translation complete |
| dtb_fault | input | 1 | Data translation fault |
| dtb_paddr | input | AW | Translated data address |
| dmem_valid | output | 1 | Data request valid |
| dmem_addr | output | AW | Data request address |
| dmem_we | output | 1 | Data request is a write |
| dmem_accept | input | 1 | Data port accepts this cycle |
| dmem_retry | input | 1 | Data port retry strobe |
| dmem_resp | input | 1 | Data response valid |
| dmem_nack | input | 1 | Data response is a negative acknowledge |

## Verification
The main flow is run with random instruction mixes of memory and non-memory words. The responders use random latencies, random refusals followed by retry strobes, random negative acknowledges and random translation faults. A scoreboard predicts every fetch address and every data address. This separates a wrong PC step, a lost parked request, and a resend with the wrong address. Directed sequences then place a drain in each kind of state: quiet, fetch wait, translation wait, and data retry or nack. They show the difference between an immediate drain and a deferred one, and between a PC that is held and one that is advanced. They also cover suspend, switch-out, a misplaced retry strobe and the counter, each in a state where the wrong behaviour would be visible at the ports.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_IRETRY = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_XWAIT  = 3'd4,
        ST_DRETRY = 3'd5,
        ST_DWAIT  = 3'd6,
        ST_OFF    = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       draining;
        logic       drained;
        logic       err;
        logic       dwrite;
    } seq_ctl_t;

endpackage

// File: rtl/seq_req_port.sv
module seq_req_port #(
    parameter int PW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send,
    input  logic [PW-1:0] send_data,
    input  logic          resend,
    input  logic          accept,
    output logic          valid,
    output logic [PW-1:0] data,
    output logic          held
);
    logic [PW-1:0] store_d, store_q;
    logic          held_d, held_q;

    always_comb begin
        valid   = send | resend;
        data    = send ? send_data : store_q;
        store_d = send ? send_data : store_q;
        held_d  = valid ? ~accept : held_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
            held_q  <= 1'b0;
        end else begin
            store_q <= store_d;
            held_q  <= held_d;
        end
    end

    assign held = held_q;
endmodule

// File: rtl/seq_cycle_ctr.sv
module seq_cycle_ctr #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb cnt_d = en ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/fetch_mem_seq.sv
module fetch_mem_seq
    import seq_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          IW        = 32,
    parameter int          CW        = 32,
    parameter logic [15:0] RESET_PC  = 16'h0100,
    parameter logic [15:0] FAULT_VEC = 16'h0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          activate,
    input  logic          suspend,
    input  logic          switch_out,
    input  logic          drain_req,
    output logic          drained,
    output logic          proto_err,
    output logic [CW-1:0] cycle_count,
    output logic          fetch_start,
    output logic [AW-1:0] fetch_pc,
    input  logic          ifetch_fault,
    output logic          imem_valid,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_accept,
    input  logic          imem_retry,
    input  logic          imem_resp,
    input  logic          imem_nack,
    input  logic [IW-1:0] imem_rdata,
    output logic          dtb_req,
    output logic [AW-1:0] dtb_vaddr,
    input  logic          dtb_done,
    input  logic          dtb_fault,
    input  logic [AW-1:0] dtb_paddr,
    output logic          dmem_valid,
    output logic [AW-1:0] dmem_addr,
    output logic          dmem_we,
    input  logic          dmem_accept,
    input  logic          dmem_retry,
    input  logic          dmem_resp,
    input  logic          dmem_nack
);
    localparam int          DPW  = AW + 1;
    localparam logic [AW-1:0] PC_STEP = AW'(4);
    localparam logic [AW-1:0] PC_RST  = AW'(RESET_PC);
    localparam logic [AW-1:0] PC_FLT  = AW'(FAULT_VEC);

    seq_ctl_t      ctl_d, ctl_q;
    logic [AW-1:0] pc_d, pc_q;
    seq_state_e    state_q;

    logic          i_send, i_resend, i_held;
    logic          d_send, d_resend, d_held;
    logic [DPW-1:0] d_data;
    logic          quiet, drain_busy, finish_drain;

    always_comb begin
        ctl_d        = ctl_q;
        pc_d         = pc_q;
        fetch_start  = 1'b0;
        i_send       = 1'b0;
        i_resend     = 1'b0;
        d_send       = 1'b0;
        d_resend     = 1'b0;
        dtb_req      = 1'b0;
        finish_drain = 1'b0;
        quiet        = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_RUN) || (ctl_q.st == ST_OFF);
        drain_busy   = ctl_q.draining | (drain_req & ~quiet);

        if (drain_req && !quiet) ctl_d.draining = 1'b1;
        if (imem_retry && (ctl_q.st != ST_IRETRY || !i_held)) ctl_d.err = 1'b1;
        if (dmem_retry && (ctl_q.st != ST_DRETRY || !d_held)) ctl_d.err = 1'b1;

        if (quiet) begin
            if (drain_req)     ctl_d.drained = 1'b1;
            else if (activate) ctl_d.drained = 1'b0;
        end

        unique case (ctl_q.st)
            ST_IDLE, ST_OFF: begin
                if (activate) ctl_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (suspend)         ctl_d.st = ST_IDLE;
                else if (switch_out) ctl_d.st = ST_OFF;
                else if (!ctl_q.drained && !drain_req) begin
                    fetch_start = 1'b1;
                    if (ifetch_fault) pc_d = PC_FLT;
                    else begin
                        i_send   = 1'b1;
                        ctl_d.st = imem_accept ? ST_IWAIT : ST_IRETRY;
                    end
                end
            end
            ST_IRETRY: begin
                if (imem_retry) begin
                    i_resend = 1'b1;
                    if (imem_accept) ctl_d.st = ST_IWAIT;
                end
            end
            ST_IWAIT: begin
                if (imem_resp) begin
                    if (imem_nack) begin
                        i_resend = 1'b1;
                        if (!imem_accept) ctl_d.st = ST_IRETRY;
                    end else if (drain_busy) begin
                        finish_drain = 1'b1;
                        ctl_d.st     = ST_RUN;
                    end else if (imem_rdata[IW-1]) begin
                        dtb_req      = 1'b1;
                        ctl_d.dwrite = imem_rdata[IW-2];
                        ctl_d.st     = ST_XWAIT;
                    end else begin
                        pc_d     = pc_q + PC_STEP;
                        ctl_d.st = ST_RUN;
                    end
                end
            end
            ST_XWAIT: begin
                if (dtb_done) begin
                    if (dtb_fault) begin
                        pc_d         = PC_FLT;
                        ctl_d.st     = ST_RUN;
                        finish_drain = drain_busy;
                    end else begin
                        d_send   = 1'b1;
                        ctl_d.st = dmem_accept ? ST_DWAIT : ST_DRETRY;
                    end
                end
            end
            ST_DRETRY: begin
                if (dmem_retry) begin
                    d_resend = 1'b1;
                    if (dmem_accept) ctl_d.st = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (dmem_resp) begin
                    if (dmem_nack) begin
                        d_resend = 1'b1;
                        if (!dmem_accept) ctl_d.st = ST_DRETRY;
                    end else begin
                        pc_d         = pc_q + PC_STEP;
                        ctl_d.st     = ST_RUN;
                        finish_drain = drain_busy;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (finish_drain) begin
            ctl_d.drained  = 1'b1;
            ctl_d.draining = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, draining: 1'b0, drained: 1'b0, err: 1'b0, dwrite: 1'b0};
            pc_q  <= PC_RST;
        end else begin
            ctl_q <= ctl_d;
            pc_q  <= pc_d;
        end
    end

    seq_req_port #(.PW(AW)) u_iport (
        .clk(clk), .rst_n(rst_n), .send(i_send), .send_data(pc_q),
        .resend(i_resend), .accept(imem_accept),
        .valid(imem_valid), .data(imem_addr), .held(i_held)
    );

    seq_req_port #(.PW(DPW)) u_dport (
        .clk(clk), .rst_n(rst_n), .send(d_send), .send_data({ctl_q.dwrite, dtb_paddr}),
        .resend(d_resend), .accept(dmem_accept),
        .valid(dmem_valid), .data(d_data), .held(d_held)
    );

    seq_cycle_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .en(ctl_q.st != ST_IDLE && ctl_q.st != ST_OFF),
        .count(cycle_count)
    );

    assign state_q   = ctl_q.st;
    assign dmem_we   = d_data[DPW-1];
    assign dmem_addr = d_data[AW-1:0];
    assign dtb_vaddr = imem_rdata[AW-1:0];
    assign fetch_pc  = pc_q;
    assign proto_err = ctl_q.err;
    assign drained   = ctl_q.drained | (drain_req & quiet);
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
#(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input seq_state_e    st,
    input logic          imem_valid,
    input logic          dmem_valid,
    input logic          imem_retry,
    input logic          dmem_retry,
    input logic          proto_err,
    input logic          drained,
    input logic          fetch_start,
    input logic [CW-1:0] cycle_count
);
    AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_valid && dmem_valid)); // R6
    AST_IMEM_ONLY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        imem_valid |-> (st == ST_RUN || st == ST_IRETRY || st == ST_IWAIT)); // R3
    AST_STRAY_RETRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ((imem_retry && st != ST_IRETRY) || (dmem_retry && st != ST_DRETRY)) |=> proto_err); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R4
    AST_NO_FETCH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !fetch_start); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_OFF) |=> cycle_count == $past(cycle_count)); // R11
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_OFF) |=> cycle_count == CW'($past(cycle_count) + 1'b1)); // R11
endmodule

bind fetch_mem_seq seq_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(state_q),
    .imem_valid(imem_valid), .dmem_valid(dmem_valid),
    .imem_retry(imem_retry), .dmem_retry(dmem_retry),
    .proto_err(proto_err), .drained(drained), .fetch_start(fetch_start),
    .cycle_count(cycle_count)
);

// File: tb/sim_fetch_mem_seq.sv
`timescale 1ns/1ps
module sim_fetch_mem_seq;
    localparam int AW = 16, IW = 32, CW = 32;
    localparam logic [15:0] RPC = 16'h0100, FVEC = 16'h0800;

    logic clk = 0, rst_n = 0;
    logic activate, suspend, switch_out, drain_req, ifetch_fault;
    logic imem_accept, imem_retry, imem_resp, imem_nack;
    logic [IW-1:0] imem_rdata;
    logic dtb_done, dtb_fault;
    logic [AW-1:0] dtb_paddr;
    logic dmem_accept, dmem_retry, dmem_resp, dmem_nack;
    logic drained, proto_err, fetch_start, imem_valid, dtb_req, dmem_valid, dmem_we;
    logic [CW-1:0] cycle_count;
    logic [AW-1:0] fetch_pc, imem_addr, dtb_vaddr, dmem_addr;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fetch_mem_seq u0 (.*);

    function automatic logic [AW-1:0] xlate(input logic [AW-1:0] v);
        return v ^ 16'h5a5a;
    endfunction

    function automatic logic [IW-1:0] mk_inst(input bit mem, input bit we, input logic [AW-1:0] a);
        return {mem, we, 14'h0, a};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        activate = 0; suspend = 0; switch_out = 0; drain_req = 0; ifetch_fault = 0;
        imem_accept = 0; imem_retry = 0; imem_resp = 0; imem_nack = 0; imem_rdata = '0;
        dtb_done = 0; dtb_fault = 0; dtb_paddr = '0;
        dmem_accept = 0; dmem_retry = 0; dmem_resp = 0; dmem_nack = 0;
    endtask

    task automatic do_reset();
        nxt(); rst_n = 0;
        nxt(); nxt(); rst_n = 1;
    endtask

    // random phase scoreboard
    bit i_out, i_held, t_pend, t_we, d_out, d_held, busy_prev;
    logic [AW-1:0] i_addr, t_va, d_addr, exp_pc;
    bit d_we;

    task automatic rand_cycle();
        bit exp_iv, exp_dv, mem;
        logic [AW-1:0] pa;
        nxt();
        imem_accept = ($urandom % 4) != 0;
        dmem_accept = ($urandom % 4) != 0;
        ifetch_fault = ($urandom % 10) == 0;
        if (i_out && ($urandom % 3) == 0) begin
            imem_resp = 1; imem_nack = ($urandom % 6) == 0;
            imem_rdata = mk_inst(($urandom % 3) == 0, $urandom % 2, AW'($urandom));
        end
        if (i_held && ($urandom % 2)) imem_retry = 1;
        if (t_pend && ($urandom % 2)) begin
            dtb_done = 1; dtb_fault = ($urandom % 6) == 0; dtb_paddr = xlate(t_va);
        end
        if (d_out && ($urandom % 3) == 0) begin dmem_resp = 1; dmem_nack = ($urandom % 6) == 0; end
        if (d_held && ($urandom % 2)) dmem_retry = 1;
        #2;
        exp_iv = 0; exp_dv = 0;
        chk(fetch_start == !busy_prev, "R2 fetch_start", fetch_start, !busy_prev);
        if (fetch_start) begin
            chk(fetch_pc == exp_pc, "R2 fetch_pc", fetch_pc, exp_pc);
            if (ifetch_fault) begin
                exp_pc = FVEC;                                    // R7
            end else begin
                exp_iv = 1;
                chk(imem_addr == exp_pc, "R2 imem_addr", imem_addr, exp_pc);
                i_addr = exp_pc;
                if (imem_accept) i_out = 1; else i_held = 1;
            end
        end
        if (imem_retry) begin
            exp_iv = 1;
            chk(imem_addr == i_addr, "R3 imem retry addr", imem_addr, i_addr);
            if (imem_accept) begin i_held = 0; i_out = 1; end
        end
        if (imem_resp) begin
            if (imem_nack) begin
                exp_iv = 1;
                chk(imem_addr == i_addr, "R5 imem nack addr", imem_addr, i_addr);
                if (!imem_accept) begin i_out = 0; i_held = 1; end
            end else begin
                i_out = 0;
                mem = imem_rdata[IW-1];
                chk(dtb_req == mem, "R6 dtb_req", dtb_req, mem);
                if (mem) begin
                    chk(dtb_vaddr == imem_rdata[AW-1:0], "R6 dtb_vaddr", dtb_vaddr, imem_rdata[AW-1:0]);
                    t_pend = 1; t_we = imem_rdata[IW-2]; t_va = imem_rdata[AW-1:0];
                end else exp_pc = exp_pc + 4;
            end
        end
        if (dtb_done) begin
            t_pend = 0;
            if (dtb_fault) exp_pc = FVEC;                         // R7
            else begin
                exp_dv = 1; pa = xlate(t_va);
                chk(dmem_addr == pa && dmem_we == t_we, "R6 dmem addr/we", {dmem_we, dmem_addr}, {t_we, pa});
                d_addr = pa; d_we = t_we;
                if (dmem_accept) d_out = 1; else d_held = 1;
            end
        end
        if (dmem_retry) begin
            exp_dv = 1;
            chk(dmem_addr == d_addr && dmem_we == d_we, "R3 dmem retry", dmem_addr, d_addr);
            if (dmem_accept) begin d_held = 0; d_out = 1; end
        end
        if (dmem_resp) begin
            if (dmem_nack) begin
                exp_dv = 1;
                chk(dmem_addr == d_addr, "R5 dmem nack addr", dmem_addr, d_addr);
                if (!dmem_accept) begin d_out = 0; d_held = 1; end
            end else begin d_out = 0; exp_pc = exp_pc + 4; end
        end
        chk(imem_valid == exp_iv, "R3 imem_valid", imem_valid, exp_iv);
        chk(dmem_valid == exp_dv, "R3 dmem_valid", dmem_valid, exp_dv);
        chk(proto_err == 0, "R4 no stray error", proto_err, 0);
        busy_prev = i_out | i_held | t_pend | d_out | d_held;
    endtask

    initial begin
        logic [CW-1:0] c0;
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        nxt(); #2;
        chk(!imem_valid && !dmem_valid && !fetch_start, "R1 no request after reset", imem_valid, 0);
        chk(drained == 0 && proto_err == 0, "R1 flags after reset", {drained, proto_err}, 0);
        chk(cycle_count == 0, "R11 count zero in idle", cycle_count, 0);
        nxt(); activate = 1; #2;
        chk(fetch_start == 0, "R1 no fetch in activate cycle", fetch_start, 0);
        nxt(); imem_accept = 1; #2;
        chk(fetch_start && fetch_pc == RPC && imem_valid && imem_addr == RPC, "R1 first fetch", fetch_pc, RPC);
        // R9 drain during instruction wait
        nxt(); drain_req = 1; #2;
        chk(drained == 0, "R9 drained low while busy", drained, 0);
        nxt(); imem_resp = 1; imem_rdata = mk_inst(0, 0, 16'h1234); #2;
        chk(drained == 0, "R9 drained low at response", drained, 0);
        nxt(); #2;
        chk(drained == 1 && fetch_start == 0, "R9 drained after ifetch response", {drained, fetch_start}, 2'b10);
        c0 = cycle_count;
        nxt(); nxt(); nxt(); #2;
        chk(cycle_count == c0 + 3, "R11 count steps in running", cycle_count, c0 + 3);
        chk(fetch_start == 0, "R9 no fetch while drained", fetch_start, 0);
        nxt(); activate = 1; #2;
        chk(fetch_start == 0, "R8 no fetch in resume cycle", fetch_start, 0);
        nxt(); imem_accept = 1; #2;
        chk(fetch_start && fetch_pc == RPC, "R9 pc held after ifetch drain", fetch_pc, RPC);
        // R6 memory instruction with drain, refusal, retry, nack
        nxt(); imem_resp = 1; imem_rdata = mk_inst(1, 1, 16'h0123); #2;
        chk(dtb_req && dtb_vaddr == 16'h0123, "R6 translation request", dtb_vaddr, 16'h0123);
        nxt(); drain_req = 1; #2;
        chk(drained == 0, "R9 drained low in translation wait", drained, 0);
        nxt(); dtb_done = 1; dtb_paddr = 16'h4321; #2;
        chk(dmem_valid && dmem_addr == 16'h4321 && dmem_we, "R6 data request", dmem_addr, 16'h4321);
        nxt(); #2;
        chk(dmem_valid == 0, "R3 parked data request stays quiet", dmem_valid, 0);
        nxt(); dmem_retry = 1; dmem_accept = 1; #2;
        chk(dmem_valid && dmem_addr == 16'h4321 && dmem_we, "R3 data resend on retry", dmem_addr, 16'h4321);
        nxt(); dmem_resp = 1; dmem_nack = 1; #2;
        chk(dmem_valid && dmem_addr == 16'h4321, "R5 data resend on nack", dmem_addr, 16'h4321);
        nxt(); dmem_retry = 1; dmem_accept = 1; #2;
        chk(dmem_valid && dmem_addr == 16'h4321, "R5 refused nack resend parked then retried", dmem_addr, 16'h4321);
        nxt(); dmem_resp = 1; #2;
        chk(drained == 0, "R9 drained low at data response", drained, 0);
        nxt(); #2;
        chk(drained && !fetch_start, "R9 drained after data response", {drained, fetch_start}, 2'b10);
        nxt(); activate = 1;
        // R8 drain while running and quiet
        nxt(); drain_req = 1; #2;
        chk(drained == 1 && fetch_start == 0, "R8 immediate drain", {drained, fetch_start}, 2'b10);
        nxt(); #2;
        chk(drained == 1 && fetch_start == 0, "R8 stays drained", {drained, fetch_start}, 2'b10);
        nxt(); activate = 1;
        nxt(); imem_accept = 1; #2;
        chk(fetch_start && fetch_pc == RPC + 4, "R9 pc advanced after data drain", fetch_pc, RPC + 4);
        // R4 stray retry
        nxt(); dmem_retry = 1; #2;
        nxt(); #2;
        chk(proto_err == 1, "R4 stray retry raises error", proto_err, 1);
        nxt(); nxt(); #2;
        chk(proto_err == 1, "R4 error sticky", proto_err, 1);

        // R10 suspend / switch-out, R7 faults
        do_reset();
        nxt(); suspend = 1; #2;
        chk(fetch_start == 0, "R10 suspend in idle no fetch", fetch_start, 0);
        nxt(); nxt(); #2;
        chk(cycle_count == 0 && !fetch_start, "R10 suspend in idle stays idle", cycle_count, 0);
        nxt(); activate = 1;
        nxt(); suspend = 1; #2;
        chk(fetch_start == 0 && !imem_valid, "R10 suspend in running", fetch_start, 0);
        nxt(); #2; c0 = cycle_count;
        nxt(); nxt(); #2;
        chk(cycle_count == c0 && !fetch_start, "R11 count holds after suspend", cycle_count, c0);
        nxt(); activate = 1;
        nxt(); switch_out = 1; #2;
        chk(fetch_start == 0, "R10 switch out no fetch", fetch_start, 0);
        nxt(); #2; c0 = cycle_count;
        nxt(); drain_req = 1; #2;
        chk(drained == 1 && !fetch_start, "R8 drain while switched out", drained, 1);
        nxt(); #2;
        chk(cycle_count == c0 + 0 && !fetch_start, "R11 count holds switched out", cycle_count, c0);
        nxt(); activate = 1;
        nxt(); ifetch_fault = 1; imem_accept = 1; #2;
        chk(fetch_start && !imem_valid, "R7 fetch fault no request", imem_valid, 0);
        nxt(); imem_accept = 1; #2;
        chk(fetch_start && fetch_pc == FVEC && imem_valid, "R7 fetch at fault vector", fetch_pc, FVEC);
        nxt(); imem_resp = 1; imem_rdata = mk_inst(1, 0, 16'h0040);
        nxt(); dtb_done = 1; dtb_fault = 1; dmem_accept = 1; #2;
        chk(!dmem_valid, "R7 data fault no request", dmem_valid, 0);
        nxt(); imem_accept = 1; #2;
        chk(fetch_start && fetch_pc == FVEC, "R7 refetch at fault vector after data fault", fetch_pc, FVEC);

        // random phase
        do_reset();
        nxt(); activate = 1;
        exp_pc = RPC; busy_prev = 0;
        i_out = 0; i_held = 0; t_pend = 0; d_out = 0; d_held = 0;
        for (int k = 0; k < 4000; k++) rand_cycle();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule